// File: doc/BRIEF.md
# Thermal Contrast Heater Controller

This block runs short heating episodes on a sweep-type thermal fingerprint sensor. Image contrast depends on the temperature difference between the finger and the die. When that contrast drops, raising the die temperature a little brings it back. Once per frame the sensor reports a 4-bit relative temperature code. Only differences between two codes carry meaning, each step is roughly 1.4 K, and the codes 0 and 15 are saturated readings that cannot be trusted.

An episode starts on a contrast-low pulse from an external comparator or on a firmware heat command. The controller takes the next valid code as its baseline and raises the heater enable. It drops the enable when the code has risen by `TARGET_STEP` codes (default 2). It also drops the enable, and raises a fault, when the heating frame budget runs out or when a saturated reading arrives. A baseline that is saturated, or already high enough that heating could push the code into saturation, is refused. The heater enable is forced low at once while the readout is in nap mode or has lost frame lock.

Top module: `contrast_heater_ctl`

## Requirements
- R1: After reset, heat_en_o, busy_o and fault_o are all 0.
- R2: While idle, a request (contrast_low_i or fw_heat_i high at a clock edge) with nap_i low and frame_lock_i high starts an episode. busy_o is 1 and fault_o is 0 after that edge, and heat_en_o stays 0 until a baseline is taken.
- R3: The first code_i seen with code_vld_i after the start is the baseline. If it is in 1..12, heat_en_o is 1 after that edge. If it is 0, 13, 14 or 15, the episode is refused: busy_o goes to 0, fault_o goes to 1, and heat_en_o is never raised.
- R4: While heating, a valid code in 1..14 that is at least baseline + TARGET_STEP (default 2) ends the episode without a fault. The heater stops and busy_o falls after that edge.
- R5: While heating, every valid code that neither ends nor faults the episode uses up one frame of budget. The TIMEOUT_FRAMES-th such frame ends the episode with fault_o = 1. Clocks without code_vld_i use no budget, and every new episode starts with a full budget.
- R6: While heating, a valid code of 0 or 15 ends the episode with fault_o = 1, even when its value meets the target.
- R7: heat_en_o is 0 in any cycle where nap_i is 1 or frame_lock_i is 0. Such a cycle abandons a running episode without a fault, and requests in such a cycle are ignored.
- R8: Requests during an episode are ignored. The baseline and the episode are unchanged.
- R9: fault_o holds its value between episodes and is cleared only when the next episode is accepted.
- R10: heat_en_o is 1 only while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_i | input | 4 | Relative temperature code from the current frame |
| code_vld_i | input | 1 | One-cycle strobe: code_i is valid |
| contrast_low_i | input | 1 | Contrast-low request from the external comparator |
| fw_heat_i | input | 1 | Firmware heat command |
| nap_i | input | 1 | Readout is in nap mode |
| frame_lock_i | input | 1 | Readout holds frame synchronisation |
| heat_en_o | output | 1 | Heater enable |
| busy_o | output | 1 | Episode in progress |
| fault_o | output | 1 | Last episode was refused, timed out or saw saturation |

## Verification
The hardest outcome to reach from the ports is the frame-budget expiry. It needs a baseline that was accepted, followed by exactly TIMEOUT_FRAMES valid codes that neither reach the target nor saturate. Idle clocks between those codes must not count, and the budget left over from one episode must not carry into the next. The bench lowers TIMEOUT_FRAMES to 6 and feeds flat and falling codes, with gaps between strobes. It then runs a second episode that reaches its target on the frame just after five misses, which shows the budget was refilled. The case of a saturated code that also meets the target comes from a baseline of 12 followed by a code of 15.

// File: rtl/contrast_heater_pkg.sv
package contrast_heater_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BASE = 2'd1,
    HS_HEAT = 2'd2
  } heat_st_e;

  // Codes at either end of the 4-bit scale are clipped readings.
  function automatic logic code_saturated(input logic [3:0] c);
    return (c == 4'd0) || (c == 4'd15);
  endfunction

  // A baseline must be unclipped and leave headroom below the refuse limit.
  function automatic logic base_usable(input logic [3:0] c, input logic [3:0] limit);
    return !code_saturated(c) && (c < limit);
  endfunction

  // Rise test in 5 bits so base + step cannot wrap.
  function automatic logic rise_reached(input logic [3:0] c, input logic [3:0] base,
                                        input logic [3:0] step);
    return {1'b0, c} >= ({1'b0, base} + {1'b0, step});
  endfunction

endpackage

// File: rtl/heat_frame_budget.sv
module heat_frame_budget #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  // High while the next spent frame would be the last one allowed.
  assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/heat_episode_fsm.sv
module heat_episode_fsm
  import contrast_heater_pkg::*;
#(
  parameter int TARGET_STEP = 2,
  parameter int REFUSE_CODE = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       permit_i,
  input  logic [3:0] code_i,
  input  logic       code_vld_i,
  input  logic       budget_last_i,
  output heat_st_e   st_o,
  output logic [3:0] base_o,
  output logic       fault_o,
  output logic       accept_evt_o,
  output logic       refuse_evt_o,
  output logic       take_evt_o,
  output logic       reach_evt_o,
  output logic       sat_evt_o,
  output logic       miss_evt_o,
  output logic       timeout_evt_o,
  output logic       abort_evt_o
);
  localparam logic [3:0] STEP  = 4'(TARGET_STEP);
  localparam logic [3:0] LIMIT = 4'(REFUSE_CODE);

  heat_st_e   st_q, st_d;
  logic [3:0] base_q;
  logic       fault_q;
  logic       heat_vld;

  assign heat_vld      = (st_q == HS_HEAT) && code_vld_i && permit_i;
  assign accept_evt_o  = (st_q == HS_IDLE) && req_i && permit_i;
  assign abort_evt_o   = (st_q != HS_IDLE) && !permit_i;
  assign take_evt_o    = (st_q == HS_BASE) && code_vld_i && permit_i && base_usable(code_i, LIMIT);
  assign refuse_evt_o  = (st_q == HS_BASE) && code_vld_i && permit_i && !base_usable(code_i, LIMIT);
  assign sat_evt_o     = heat_vld && code_saturated(code_i);
  assign reach_evt_o   = heat_vld && !code_saturated(code_i) && rise_reached(code_i, base_q, STEP);
  assign miss_evt_o    = heat_vld && !code_saturated(code_i) && !rise_reached(code_i, base_q, STEP);
  assign timeout_evt_o = miss_evt_o && budget_last_i;

  always_comb begin
    st_d = st_q;
    if (abort_evt_o)                                    st_d = HS_IDLE;
    else if (accept_evt_o)                              st_d = HS_BASE;
    else if (take_evt_o)                                st_d = HS_HEAT;
    else if (refuse_evt_o || sat_evt_o || reach_evt_o || timeout_evt_o) st_d = HS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_IDLE;
      base_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take_evt_o) base_q <= code_i;
      if (accept_evt_o) fault_q <= 1'b0;
      else if (refuse_evt_o || sat_evt_o || timeout_evt_o) fault_q <= 1'b1;
    end
  end

  assign st_o    = st_q;
  assign base_o  = base_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/contrast_heater_ctl.sv
module contrast_heater_ctl
  import contrast_heater_pkg::*;
#(
  parameter int TARGET_STEP    = 2,
  parameter int TIMEOUT_FRAMES = 1000,
  parameter int REFUSE_CODE    = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code_i,
  input  logic       code_vld_i,
  input  logic       contrast_low_i,
  input  logic       fw_heat_i,
  input  logic       nap_i,
  input  logic       frame_lock_i,
  output logic       heat_en_o,
  output logic       busy_o,
  output logic       fault_o
);
  // Named internal events, visible to the bound checker.
  heat_st_e   st;
  logic [3:0] base_q;
  logic       permit, req;
  logic       accept_evt, refuse_evt, take_evt, reach_evt, sat_evt;
  logic       miss_evt, timeout_evt, abort_evt, budget_last;

  assign permit = !nap_i && frame_lock_i;
  assign req    = contrast_low_i || fw_heat_i;

  heat_episode_fsm #(
    .TARGET_STEP (TARGET_STEP),
    .REFUSE_CODE (REFUSE_CODE)
  ) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req),
    .permit_i      (permit),
    .code_i        (code_i),
    .code_vld_i    (code_vld_i),
    .budget_last_i (budget_last),
    .st_o          (st),
    .base_o        (base_q),
    .fault_o       (fault_o),
    .accept_evt_o  (accept_evt),
    .refuse_evt_o  (refuse_evt),
    .take_evt_o    (take_evt),
    .reach_evt_o   (reach_evt),
    .sat_evt_o     (sat_evt),
    .miss_evt_o    (miss_evt),
    .timeout_evt_o (timeout_evt),
    .abort_evt_o   (abort_evt)
  );

  heat_frame_budget #(
    .LIMIT (TIMEOUT_FRAMES)
  ) budget_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept_evt),
    .tick_i (miss_evt),
    .last_o (budget_last)
  );

  // Gated without a register so nap or lock loss drops the heater in the same cycle.
  assign heat_en_o = (st == HS_HEAT) && permit;
  assign busy_o    = (st != HS_IDLE);
endmodule

// File: rtl/contrast_heater_ctl_chk.sv
module contrast_heater_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nap_i,
  input logic       frame_lock_i,
  input logic       heat_en_o,
  input logic       busy_o,
  input logic       fault_o,
  input logic [1:0] st,
  input logic [3:0] base_q,
  input logic       accept_evt,
  input logic       refuse_evt,
  input logic       reach_evt,
  input logic       sat_evt,
  input logic       timeout_evt,
  input logic       abort_evt
);
  p_heat_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    heat_en_o |-> busy_o);

  p_heat_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_i || !frame_lock_i) |-> !heat_en_o);

  p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy_o && $stable(fault_o));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy_o && !fault_o && !heat_en_o);

  p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_evt |=> !busy_o && fault_o);

  p_reach_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reach_evt |=> !busy_o && !fault_o);

  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !busy_o && fault_o);

  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> !busy_o && fault_o);

  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |=> (st != 2'd2) || $stable(base_q));

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !accept_evt) |=> $stable(fault_o));
endmodule

bind contrast_heater_ctl contrast_heater_ctl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .nap_i        (nap_i),
  .frame_lock_i (frame_lock_i),
  .heat_en_o    (heat_en_o),
  .busy_o       (busy_o),
  .fault_o      (fault_o),
  .st           (st),
  .base_q       (base_q),
  .accept_evt   (accept_evt),
  .refuse_evt   (refuse_evt),
  .reach_evt    (reach_evt),
  .sat_evt      (sat_evt),
  .timeout_evt  (timeout_evt),
  .abort_evt    (abort_evt)
);

// File: tb/contrast_heater_ctl_tb.sv
`timescale 1ns/1ps
module contrast_heater_ctl_tb_top;
  localparam int STEP = 2;
  localparam int TMO  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] code = '0;
  logic vld = 1'b0, clow = 1'b0, fwh = 1'b0, nap = 1'b0, lock = 1'b1;
  logic heat, busy, fault;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  contrast_heater_ctl #(.TARGET_STEP(STEP), .TIMEOUT_FRAMES(TMO), .REFUSE_CODE(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .code_i(code), .code_vld_i(vld),
    .contrast_low_i(clow), .fw_heat_i(fwh), .nap_i(nap), .frame_lock_i(lock),
    .heat_en_o(heat), .busy_o(busy), .fault_o(fault));

  // exp = {heat, busy, fault}
  task automatic chk(input string tag, input logic [2:0] exp);
    total++;
    if ({heat, busy, fault} !== exp) begin
      fails++;
      $display("FAIL %s act={heat,busy,fault}=%b exp=%b", tag, {heat, busy, fault}, exp);
    end
  endtask

  task automatic start(input bit use_fw);
    @(negedge clk);
    if (use_fw) fwh = 1'b1; else clow = 1'b1;
    @(negedge clk);
    fwh = 1'b0; clow = 1'b0;
  endtask

  task automatic frame(input logic [3:0] c);
    @(negedge clk);
    code = c; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 3'b000);
    rst_n = 1'b1;

    // Baseline sweep over every code
    for (int b = 0; b < 16; b++) begin
      start(b[0]);
      chk("R2 start", 3'b010);
      frame(4'(b));
      if (b >= 1 && b <= 12) begin
        chk("R3 baseline taken", 3'b110);
        frame(4'(b + 1));
        chk("R4 one step short", 3'b110);
        @(negedge clk);
        chk("R5 idle clock no change", 3'b110);
        frame(4'(b + STEP));
        chk("R4 target reached", 3'b000);
      end else begin
        chk("R3 baseline refused", 3'b001);
        repeat (3) @(negedge clk);
        chk("R9 fault held", 3'b001);
      end
    end

    // Budget expiry with gaps and falling codes
    start(1'b0);
    chk("R9 fault cleared on accept", 3'b010);
    frame(4'd5);
    for (int k = 1; k < TMO; k++) begin
      frame((k % 2) ? 4'd5 : 4'd3);
      @(negedge clk);
      chk("R5 budget not spent", 3'b110);
    end
    frame(4'd6);
    chk("R5 timeout", 3'b001);

    // New episode gets a full budget
    start(1'b1);
    frame(4'd7);
    for (int k = 1; k < TMO; k++) frame(4'd7);
    chk("R5 budget refilled", 3'b110);
    frame(4'd9);
    chk("R5 reach after five misses", 3'b000);

    // Saturation beats the target
    start(1'b0);
    frame(4'd12);
    frame(4'd15);
    chk("R6 code 15 faults", 3'b001);
    start(1'b0);
    frame(4'd4);
    frame(4'd0);
    chk("R6 code 0 faults", 3'b001);

    // Nap and lock loss
    start(1'b0);
    frame(4'd6);
    nap = 1'b1; #1;
    chk("R7 nap drops heater at once", 3'b010);
    @(negedge clk);
    chk("R7 nap abandons episode", 3'b000);
    start(1'b1);
    chk("R7 request ignored in nap", 3'b000);
    nap = 1'b0;
    start(1'b0);
    frame(4'd6);
    lock = 1'b0; #1;
    chk("R7 lock loss drops heater", 3'b010);
    @(negedge clk);
    chk("R7 lock loss abandons", 3'b000);
    start(1'b0);
    chk("R7 request ignored unlocked", 3'b000);
    lock = 1'b1;

    // Requests while busy
    start(1'b0);
    start(1'b1);
    frame(4'd6);
    chk("R8 baseline after repeat request", 3'b110);
    start(1'b0);
    chk("R10 heater still tied to busy", 3'b110);
    frame(4'd7);
    chk("R8 baseline kept", 3'b110);
    frame(4'd8);
    chk("R8 stop at original target", 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule